// File: doc/BRIEF.md
# Comparator Timer Channel

This block is one channel of an event timer. It watches a free-running main counter that is supplied from outside and emits a one-cycle `fire_o` pulse when the counter reaches a programmed comparator value. In one-shot mode the channel fires once and then waits to be re-armed. In periodic mode it fires and then advances its comparator by a stored period. If the counter has run several periods past the comparator, the channel adds the period once per cycle until the comparator is ahead again, so missed periods do not produce a burst of events.

A narrow mode restricts all comparisons and arithmetic to the low half of the counter. In narrow one-shot mode, when the counter must wrap through all ones before it can reach the comparator, the channel raises an extra event at the wrap and then fires again at the real match.

Software-style writes reach the channel as plain strobes with a shared data bus: one for the configuration and one for each comparator half. The channel drives two signals for a separate interrupt router: `level_o`, which reports the interrupt type chosen by software, and `drop_o`, which tells the router to withdraw a pending interrupt. The block has no streaming data path. All pins are plain control and status signals without handshake, and at most one write strobe is asserted per cycle.

Top module: `tmr_chan`

## Requirements
- R1: During and after reset `fire_o`, `drop_o` and `level_o` are low, the comparator holds all ones, the period holds zero and no wrap event is pending.
- R2: The counter has reached the comparator when (comparator − count), taken as a signed number of the active width, is zero or negative. The active width is the full counter, or only the low halves in narrow mode. A count that is numerically larger but more than half the range away does not count as reached.
- R3: An armed and enabled one-shot channel pulses `fire_o` high for exactly one cycle, in the cycle after the clock edge at which it sees the count reach the comparator. It then stays silent until it is armed again.
- R4: The channel is armed in three cases, each while `glb_en_i` is high: when the enable field changes from 0 to 1; when either comparator half is written while the enable field is 1; and when `glb_en_i` rises while the enable field is 1 and the comparator is not all ones. No event is produced from the edge at which a write strobe is high or the channel is armed.
- R5: In periodic mode with a nonzero period, an event adds the period to the comparator. The channel then adds the period once per cycle, without firing, until the comparator is ahead of the count.
- R6: A low-half comparator write loads the comparator low half when the channel is one-shot or the set-value field is 1. In periodic mode it always loads the period low half. A high-half write, outside narrow mode, loads the comparator high half under the same condition and otherwise loads the period high half. In narrow mode a high-half write is ignored. Any comparator write clears the set-value field.
- R7: A value written to the period has its top bit forced to zero. The top bit is bit 63 for a high-half write, and bit 31 for a low-half write in narrow mode.
- R8: A configuration write that selects narrow mode clears the upper halves of the comparator and the period, so a later return to wide mode compares against the truncated value.
- R9: When a narrow one-shot channel is armed while the comparator lies beyond the wrap of the low counter half, it fires once on the edge where the low half is all ones. It then fires again on the real match.
- R10: When the enable field falls, the channel is disarmed and any pending wrap event is cancelled. When `glb_en_i` falls while the channel is enabled, the same happens. Either event pulses `drop_o` for one cycle. No event is produced while `glb_en_i` is low or the enable field is 0.
- R11: `level_o` follows the interrupt-type field of the configuration from the edge at which that field is written.
- Configuration bits in `cfg_wdata_i`: bit 0 enable, bit 1 periodic, bit 2 level type, bit 3 set-value, bit 4 narrow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | CNT_W | Current main counter value |
| glb_en_i | input | 1 | Global enable for all channels |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 5 | Configuration write value |
| cmp_lo_we_i | input | 1 | Comparator low-half write strobe |
| cmp_hi_we_i | input | 1 | Comparator high-half write strobe |
| wdata_i | input | CNT_W/2 | Comparator write value |
| fire_o | output | 1 | One-cycle event pulse |
| drop_o | output | 1 | One-cycle request to withdraw a pending interrupt |
| level_o | output | 1 | Interrupt type flag, 1 for level |

## Verification
Some properties are checked by assertions on every cycle. No event follows a write edge or a cycle with the channel disabled. The catch-up phase never fires. A pending wrap event implies the channel is armed. The set-value field clears after a comparator write. The period's top bit stays zero, and narrow mode keeps both upper halves at zero. Other behaviour shows only through the bench's scenarios, because it depends on what was stored earlier: which register a comparator write was steered to, how many cycles catch-up takes, whether a masked period lands on the right count, and where the wrap and real-match events fall in narrow one-shot mode.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  // field order is the bit layout of the configuration write bus (MSB first)
  typedef struct packed {
    logic narrow;
    logic setval;
    logic level;
    logic periodic;
    logic enable;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_chan_pkg::*;
#(
  parameter  int CNT_W  = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  chan_cfg_t         cfg_wdata,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [HALF_W-1:0] wdata,
  input  logic              reload,
  output chan_cfg_t         cfg_q,
  output chan_cfg_t         cfg_nx,
  output logic [CNT_W-1:0]  cmp_q,
  output logic [CNT_W-1:0]  cmp_nx,
  output logic [CNT_W-1:0]  per_q
);
  localparam logic [HALF_W-1:0] TOP_CLR = {1'b0, {(HALF_W-1){1'b1}}};

  logic [CNT_W-1:0]  per_nx;
  logic [CNT_W-1:0]  sum;
  logic              to_cmp;
  logic [HALF_W-1:0] lo_mask;

  assign sum     = cmp_q + per_q;
  assign to_cmp  = !cfg_q.periodic || cfg_q.setval;
  assign lo_mask = cfg_q.narrow ? TOP_CLR : '1;

  always_comb begin
    cfg_nx = cfg_q;
    cmp_nx = cmp_q;
    per_nx = per_q;
    if (reload) begin
      cmp_nx = cfg_q.narrow ? {{HALF_W{1'b0}}, sum[HALF_W-1:0]} : sum;
    end
    if (lo_we) begin
      if (to_cmp)         cmp_nx[HALF_W-1:0] = wdata;
      if (cfg_q.periodic) per_nx[HALF_W-1:0] = wdata & lo_mask;
    end
    if (hi_we && !cfg_q.narrow) begin
      if (to_cmp) cmp_nx[CNT_W-1:HALF_W] = wdata;
      else        per_nx[CNT_W-1:HALF_W] = wdata & TOP_CLR;
    end
    if (lo_we || hi_we) cfg_nx.setval = 1'b0;
    if (cfg_we) begin
      cfg_nx = cfg_wdata;
      if (cfg_wdata.narrow) begin
        cmp_nx[CNT_W-1:HALF_W] = '0;
        per_nx[CNT_W-1:HALF_W] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cmp_q <= '1;
      per_q <= '0;
    end else begin
      cfg_q <= cfg_nx;
      cmp_q <= cmp_nx;
      per_q <= per_nx;
    end
  end

  AST_SETVAL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we || hi_we) && !cfg_we |=> !cfg_q.setval) else $error("setval kept"); // R6

  AST_PERIOD_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !per_q[CNT_W-1]) else $error("period top bit set"); // R7

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.narrow |-> (cmp_q[CNT_W-1:HALF_W] == '0) && (per_q[CNT_W-1:HALF_W] == '0))
    else $error("narrow upper half nonzero"); // R8
endmodule

// File: rtl/tmr_chan_order.sv
module tmr_chan_order #(
  parameter  int CNT_W  = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] cnt,
  input  logic             narrow,
  output logic             reached,
  output logic             wrap_first
);
  logic signed [CNT_W-1:0]  d_wide;
  logic signed [HALF_W-1:0] d_half;

  assign d_wide = signed'(cmp - cnt);
  assign d_half = signed'(cmp[HALF_W-1:0] - cnt[HALF_W-1:0]);

  assign reached    = narrow ? (d_half <= 0) : (d_wide <= 0);
  // target is ahead, yet numerically below the count: it lies past the wrap
  assign wrap_first = (cmp[HALF_W-1:0] < cnt[HALF_W-1:0]) && (d_half > 0);
endmodule

// File: rtl/tmr_chan_ctrl.sv
module tmr_chan_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic glb_en,
  input  logic cur_en,
  input  logic cur_periodic,
  input  logic nx_en,
  input  logic nx_periodic,
  input  logic nx_narrow,
  input  logic cmp_wr,
  input  logic wr_any,
  input  logic cmp_ones,
  input  logic per_zero,
  input  logic reached,
  input  logic wrap_arm,
  input  logic low_ones,
  output logic reload,
  output logic fire_o,
  output logic drop_o
);
  logic armed_q, catch_q, wrap_q, glb_q;
  logic en_rise, en_fall, glb_rise, glb_fall;
  logic arm, disarm, live, repeat_on;

  assign en_rise   = nx_en && !cur_en;
  assign en_fall   = cur_en && !nx_en;
  assign glb_rise  = glb_en && !glb_q;
  assign glb_fall  = !glb_en && glb_q;
  assign disarm    = en_fall || !glb_en;
  assign arm       = glb_en && nx_en && (en_rise || cmp_wr || (glb_rise && !cmp_ones));
  assign live      = armed_q && cur_en && glb_en && !wr_any && !arm && !disarm;
  assign repeat_on = cur_periodic && !per_zero;
  assign reload    = live && reached && (catch_q || (!wrap_q && repeat_on));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      catch_q <= 1'b0;
      wrap_q  <= 1'b0;
      glb_q   <= 1'b0;
      fire_o  <= 1'b0;
      drop_o  <= 1'b0;
    end else begin
      glb_q  <= glb_en;
      fire_o <= 1'b0;
      drop_o <= en_fall || (glb_fall && cur_en);
      if (disarm) begin
        armed_q <= 1'b0;
        catch_q <= 1'b0;
        wrap_q  <= 1'b0;
      end else if (arm) begin
        armed_q <= 1'b1;
        catch_q <= 1'b0;
        wrap_q  <= nx_narrow && !nx_periodic && wrap_arm;
      end else if (live) begin
        if (catch_q) begin
          if (!reached) catch_q <= 1'b0;
        end else if (wrap_q) begin
          if (low_ones) begin
            fire_o <= 1'b1;
            wrap_q <= 1'b0;
          end
        end else if (reached) begin
          fire_o <= 1'b1;
          if (repeat_on) catch_q <= 1'b1;
          else           armed_q <= 1'b0;
        end
      end
    end
  end

  AST_NO_FIRE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(glb_en) && $past(cur_en)) else $error("event while disabled"); // R10

  AST_NO_FIRE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> !$past(wr_any)) else $error("event on write edge"); // R4

  AST_CATCHUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    catch_q |=> !fire_o) else $error("event during catch-up"); // R5

  AST_WRAP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> armed_q) else $error("wrap pending while disarmed"); // R9
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter  int CNT_W  = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              glb_en_i,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              cmp_lo_we_i,
  input  logic              cmp_hi_we_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic              fire_o,
  output logic              drop_o,
  output logic              level_o
);
  chan_cfg_t        cfg_q, cfg_nx;
  logic [CNT_W-1:0] cmp_q, cmp_nx, per_q;
  logic             reload, reached_cur, wrap_nx;
  logic             unused_wrap_cur, unused_reached_nx;

  tmr_chan_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we_i),
    .cfg_wdata (chan_cfg_t'(cfg_wdata_i)),
    .lo_we     (cmp_lo_we_i),
    .hi_we     (cmp_hi_we_i),
    .wdata     (wdata_i),
    .reload    (reload),
    .cfg_q     (cfg_q),
    .cfg_nx    (cfg_nx),
    .cmp_q     (cmp_q),
    .cmp_nx    (cmp_nx),
    .per_q     (per_q)
  );

  // ordering against the live comparator decides events
  tmr_chan_order #(.CNT_W(CNT_W)) u_ord_cur (
    .cmp        (cmp_q),
    .cnt        (count_i),
    .narrow     (cfg_q.narrow),
    .reached    (reached_cur),
    .wrap_first (unused_wrap_cur)
  );

  // ordering against the value about to be stored decides wrap arming
  tmr_chan_order #(.CNT_W(CNT_W)) u_ord_nx (
    .cmp        (cmp_nx),
    .cnt        (count_i),
    .narrow     (cfg_nx.narrow),
    .reached    (unused_reached_nx),
    .wrap_first (wrap_nx)
  );

  tmr_chan_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .glb_en       (glb_en_i),
    .cur_en       (cfg_q.enable),
    .cur_periodic (cfg_q.periodic),
    .nx_en        (cfg_nx.enable),
    .nx_periodic  (cfg_nx.periodic),
    .nx_narrow    (cfg_nx.narrow),
    .cmp_wr       (cmp_lo_we_i || cmp_hi_we_i),
    .wr_any       (cfg_we_i || cmp_lo_we_i || cmp_hi_we_i),
    .cmp_ones     (&cmp_q),
    .per_zero     (per_q == '0),
    .reached      (reached_cur),
    .wrap_arm     (wrap_nx),
    .low_ones     (&count_i[HALF_W-1:0]),
    .reload       (reload),
    .fire_o       (fire_o),
    .drop_o       (drop_o)
  );

  assign level_o = cfg_q.level;
endmodule

// File: tb/tmr_chan_bench.sv
module tmr_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 64;
  localparam int HALF_W = CNT_W / 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CNT_W-1:0]  count_i = '0;
  logic              glb_en_i = 1'b0;
  logic              cfg_we_i = 1'b0;
  logic [4:0]        cfg_wdata_i = '0;
  logic              cmp_lo_we_i = 1'b0;
  logic              cmp_hi_we_i = 1'b0;
  logic [HALF_W-1:0] wdata_i = '0;
  logic              fire_o, drop_o, level_o;

  tmr_chan #(.CNT_W(CNT_W)) u_tmr_chan (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .glb_en_i(glb_en_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .cmp_lo_we_i(cmp_lo_we_i),
    .cmp_hi_we_i(cmp_hi_we_i), .wdata_i(wdata_i),
    .fire_o(fire_o), .drop_o(drop_o), .level_o(level_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  // staged inputs, applied by the driver at the next falling edge
  logic              s_cfg_we = 0, s_lo = 0, s_hi = 0, s_glb = 1;
  logic [4:0]        s_cfg = '0;
  logic [HALF_W-1:0] s_wd = '0;
  logic [CNT_W-1:0]  s_cnt = '0;
  logic              lvl_exp = 0;

  task automatic tick(input logic fe, input logic de, input string tag);
    @(negedge clk);
    cfg_we_i = s_cfg_we; cfg_wdata_i = s_cfg; cmp_lo_we_i = s_lo;
    cmp_hi_we_i = s_hi; wdata_i = s_wd; count_i = s_cnt; glb_en_i = s_glb;
    exp_q.push_back({fe, de, lvl_exp});
    tag_q.push_back(tag);
    s_cfg_we = 0; s_lo = 0; s_hi = 0;
  endtask

  // cfg bits: {narrow, setval, level, periodic, enable}
  task automatic cfgw(input logic en, input logic per, input logic lvl, input logic sv,
                      input logic nar, input logic fe, input logic de, input string tag);
    s_cfg_we = 1; s_cfg = {nar, sv, lvl, per, en}; lvl_exp = lvl;
    tick(fe, de, tag);
  endtask

  task automatic wlo(input logic [HALF_W-1:0] v, input string tag);
    s_lo = 1; s_wd = v; tick(0, 0, tag);
  endtask

  task automatic whi(input logic [HALF_W-1:0] v, input string tag);
    s_hi = 1; s_wd = v; tick(0, 0, tag);
  endtask

  // monitor: compares each expected item against the outputs after its edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if ({fire_o, drop_o, level_o} !== e) begin
          n_bad++;
          $display("FAIL %s: actual fire/drop/level=%b expected %b", t, {fire_o, drop_o, level_o}, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if ({fire_o, drop_o, level_o} !== 3'b000) begin
      n_bad++;
      $display("FAIL R1 in reset: actual %b expected 000", {fire_o, drop_o, level_o});
    end
    rst_n = 1;

    // R1: comparator comes out of reset as all ones
    s_cnt = 64'hFFFF_FFFF_FFFF_FFFD;
    tick(0, 0, "R1 idle after reset");
    cfgw(1, 0, 0, 0, 0, 0, 0, "R4 enable rise arms");
    s_cnt = 64'hFFFF_FFFF_FFFF_FFFE; tick(0, 0, "R2 one before all ones");
    s_cnt = 64'hFFFF_FFFF_FFFF_FFFF; tick(1, 0, "R1 reset comparator all ones");
    tick(0, 0, "R3 single pulse");

    // R3 one-shot, R11 level type, R4 re-arm by write
    cfgw(0, 0, 0, 0, 0, 0, 1, "R10 enable fall drops");
    s_cnt = 0;
    wlo(100, "R6 low write one-shot");
    whi(0, "R6 high write one-shot");
    cfgw(1, 0, 1, 0, 0, 0, 0, "R11 level type written");
    s_cnt = 99;  tick(0, 0, "R3 before match");
    s_cnt = 100; tick(1, 0, "R3 match fires");
    s_cnt = 101; tick(0, 0, "R3 after match");
    s_cnt = 100; tick(0, 0, "R3 no refire");
    wlo(120, "R4 write re-arms");
    s_cnt = 119; tick(0, 0, "R4 before match");
    s_cnt = 120; tick(1, 0, "R4 re-armed match");
    s_cnt = 64'h8000_0000_0000_0200;
    wlo(120, "R4 write re-arms");
    tick(0, 0, "R2 count half range away not reached");
    s_cnt = 120; tick(1, 0, "R2 reached");

    // R5 periodic catch-up, R6 set-value steering
    cfgw(0, 1, 0, 1, 0, 0, 1, "R10 enable fall drops");
    s_cnt = 0;
    wlo(200, "R6 setval low write");
    wlo(10, "R6 periodic low write to period");
    cfgw(1, 1, 0, 0, 0, 0, 0, "R4 arm periodic");
    s_cnt = 199; tick(0, 0, "R6 comparator kept by steering");
    s_cnt = 235; tick(1, 0, "R5 periodic fire");
    for (int i = 0; i < 5; i++) tick(0, 0, "R5 catch-up silent");
    s_cnt = 239; tick(0, 0, "R5 before caught-up target");
    s_cnt = 240; tick(1, 0, "R5 caught-up target");
    s_cnt = 249; tick(0, 0, "R5 before next period");
    s_cnt = 250; tick(1, 0, "R5 next period");

    // R7 wide period mask via high-half write
    cfgw(0, 1, 0, 1, 0, 0, 1, "R10 enable fall drops");
    s_cnt = 0;
    wlo(5, "R6 setval low write");
    wlo(0, "R6 period low write");
    whi(32'h8000_0001, "R7 period high write masked");
    cfgw(1, 1, 0, 0, 0, 0, 0, "R4 arm periodic");
    s_cnt = 5; tick(1, 0, "R5 fire at 5");
    tick(0, 0, "R5 caught up");
    s_cnt = 64'h1_0000_0004; tick(0, 0, "R7 before masked period");
    s_cnt = 64'h1_0000_0005; tick(1, 0, "R7 masked period lands");

    // R7 narrow period mask, R2 narrow ordering
    cfgw(0, 1, 0, 1, 1, 0, 1, "R10 enable fall drops");
    wlo(5, "R6 setval low write narrow");
    wlo(32'h8000_0010, "R7 narrow low period write");
    cfgw(1, 1, 0, 0, 1, 0, 0, "R4 arm narrow periodic");
    s_cnt = 64'h7_0000_0005; tick(1, 0, "R2 narrow uses low halves");
    tick(0, 0, "R5 caught up");
    s_cnt = 64'h7_0000_0014; tick(0, 0, "R7 before narrow period");
    s_cnt = 64'h7_0000_0015; tick(1, 0, "R7 narrow mask lands");

    // R9 wrap event, R8 truncation
    cfgw(0, 0, 0, 0, 0, 0, 1, "R10 enable fall drops");
    whi(32'h0000_0ABC, "R6 high write one-shot");
    wlo(32'h10, "R6 low write one-shot");
    s_cnt = 64'h5_FFFF_FFF0;
    cfgw(0, 0, 0, 0, 1, 0, 0, "R8 select narrow");
    cfgw(1, 0, 0, 0, 1, 0, 0, "R9 arm past wrap");
    s_cnt = 64'h5_FFFF_FFFE; tick(0, 0, "R9 before wrap");
    s_cnt = 64'h5_FFFF_FFFF; tick(1, 0, "R9 wrap event");
    s_cnt = 64'h6_0000_0000; tick(0, 0, "R9 after wrap");
    s_cnt = 64'h6_0000_000F; tick(0, 0, "R9 before real match");
    s_cnt = 64'h6_0000_0010; tick(1, 0, "R9 real match");
    s_cnt = 64'h6_0000_0011; tick(0, 0, "R9 done");
    s_cnt = 64'h10;
    cfgw(0, 0, 0, 0, 0, 0, 1, "R10 enable fall drops");
    cfgw(1, 0, 0, 0, 0, 0, 0, "R4 arm wide");
    tick(1, 0, "R8 comparator upper half truncated");

    // R10 global enable, R4 global rise
    s_glb = 0; tick(0, 1, "R10 global fall drops");
    wlo(32'h40, "R4 write while global off");
    s_cnt = 64'h50;
    tick(0, 0, "R10 no event while global off");
    tick(0, 0, "R10 no event while global off");
    s_glb = 1; tick(0, 0, "R4 global rise arms");
    tick(1, 0, "R4 global rise match");
    tick(0, 0, "R3 quiet");

    repeat (3) @(posedge clk);
    #2;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule